// File: doc/BRIEF.md
# TDM Slot Receiver

This block is the receive side of a synchronous serial port working in time-division network mode. A bit clock, a frame sync and a serial data line come in. The block shifts a bit in on every falling bit-clock edge. At the end of each time slot it moves the finished word into a receive data register. It marks that register full and, when enabled, raises an interrupt.

Every slot of the frame is captured. The block does not decide which slots the host keeps. With each word it stores a frame-start flag, so the host can rebuild the slot index of every word it reads. A new word that lands while the register is still full is reported as an overrun.

The host reads the data and status words through a one-address-bit register read port. The slot count, word length, frame-sync length and interrupt enable arrive as static configuration inputs.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset, the status word (`rdAddr`=1) and the data word (`rdAddr`=0) both read zero, and `irq` is low.
- R2: Bits are sampled from `sdIn` at each falling edge of `sclk`, most significant bit first.
  - The word length follows `wlCode`: 00 gives 8 bits, 01 gives 12, 10 gives 16 and 11 gives 24.
  - The word is right-aligned in the data register, and the bits above it read zero.
- R3: Every slot transfers a word. A frame holds `slotCfg`+1 slots. The slot position wraps at the end of a frame even when no frame sync arrives.
- R4: Status bit 2 is set for the word held in the data register if that word came from the first slot of a frame, and clear otherwise.
- R5: The frame-sync length is chosen by `fsWordLen`.
  - When `fsWordLen`=1, the sync is high for the whole first word, and its rising edge coincides with that word's first bit.
  - When `fsWordLen`=0, the sync is a one-bit pulse sampled one bit before the frame's first bit.
- R6: Status bit 0 (full) sets on each transfer and clears on a data-register read.
- R7: `irq` is high exactly when the full bit is set and `rie` is 1.
- R8: Status bit 1 (overrun) sets when a transfer occurs while full is still set. The new word overwrites the data register.
- R9: Overrun clears only on a data read that follows a status read made while overrun was set. A data read alone leaves it set.
- R10: While `enable` is 0, nothing is captured. After `enable` is set, capture starts only at the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable |
| rie | input | 1 | Receive interrupt enable |
| slotCfg | input | 5 | Slots per frame minus one |
| wlCode | input | 2 | Word length code |
| fsWordLen | input | 1 | 1: word-long frame sync, 0: one-bit early sync |
| sclk | input | 1 | Bit clock, synchronous to clk |
| fsIn | input | 1 | Frame sync |
| sdIn | input | 1 | Serial data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 1 | 0: data register, 1: status register |
| rdData | output | 24 | Read data |
| irq | output | 1 | Receive interrupt |

## Verification
Random words are sent in every word length, with both sync styles, slot counts from 2 to 32, and the interrupt enable both on and off. Some runs suppress the second frame's sync, so that the frame flag can only come from the slot counter wrapping and not from a resync.

Directed runs cover three further cases:
- A skipped read, which separates overwrite-on-overrun from keep-old-data.
- A read ordering of data first, then status, then data, which separates the status-then-data clearing rule from a clear on any read.
- An enable raised in the middle of a frame, which shows whether capture waits for the next sync.

// File: rtl/tdm_slot_rx_pkg.sv
package tdm_slot_rx_pkg;
  typedef struct packed {
    logic shift;
    logic xfer;
    logic first;
  } rxStrobeT;

  function automatic int unsigned wlBits(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 12;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/tdm_slot_rx_ctrl.sv
module tdm_slot_rx_ctrl
  import tdm_slot_rx_pkg::*;
#(
  parameter int MAX_WL = 24,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SLOT_W-1:0] slotCfg,
  input  logic [1:0]        wlCode,
  input  logic              fsWordLen,
  input  logic              sclk,
  input  logic              fsIn,
  output rxStrobeT          strb
);
  localparam int CNT_W = $clog2(MAX_WL + 1);

  logic              sclkQ, fsS, fsS2, running;
  logic [CNT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slot;
  logic              sample, startNow, lastBit;
  logic [CNT_W-1:0]  wlLast;

  always_comb begin
    sample   = sclkQ & ~sclk;
    wlLast   = CNT_W'(wlBits(wlCode) - 1);
    lastBit  = (bitCnt == wlLast);
    startNow = enable & (fsWordLen ? (fsIn & ~fsS) : (fsS & ~fsS2));
    strb.shift = sample & enable & (running | startNow);
    strb.xfer  = sample & enable & running & ~startNow & lastBit;
    strb.first = (slot == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      fsS     <= 1'b0;
      fsS2    <= 1'b0;
      running <= 1'b0;
      bitCnt  <= '0;
      slot    <= '0;
    end else begin
      sclkQ <= sclk;
      if (sample) begin
        fsS  <= fsIn;
        fsS2 <= fsS;
      end
      if (!enable) begin
        running <= 1'b0;
      end else if (sample) begin
        if (startNow) begin
          running <= 1'b1;
          bitCnt  <= CNT_W'(1);
          slot    <= '0;
        end else if (running) begin
          if (lastBit) begin
            bitCnt <= '0;
            slot   <= (slot == slotCfg) ? '0 : slot + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_rx_dp.sv
module tdm_slot_rx_dp
  import tdm_slot_rx_pkg::*;
#(
  parameter int MAX_WL = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strb,
  input  logic              sdIn,
  input  logic [1:0]        wlCode,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [MAX_WL-1:0] rdData,
  output logic              rxFull,
  output logic              ovr
);
  logic [MAX_WL-1:0] shiftReg, rxData, nextSr, wordMask;
  logic              frameFlag, ovrSeen, dataRd, statRd, newOvr;

  always_comb begin
    nextSr   = {shiftReg[MAX_WL-2:0], sdIn};
    wordMask = (MAX_WL'(1) << wlBits(wlCode)) - MAX_WL'(1);
    dataRd   = rdEn & ~rdAddr;
    statRd   = rdEn & rdAddr;
    newOvr   = strb.xfer & rxFull & ~dataRd;
    rdData   = rdAddr ? MAX_WL'({frameFlag, ovr, rxFull}) : rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      frameFlag <= 1'b0;
      rxFull    <= 1'b0;
      ovr       <= 1'b0;
      ovrSeen   <= 1'b0;
    end else begin
      if (strb.shift) shiftReg <= nextSr;
      if (strb.xfer) begin
        rxData    <= nextSr & wordMask;
        frameFlag <= strb.first;
        rxFull    <= 1'b1;
      end else if (dataRd) begin
        rxFull <= 1'b0;
      end
      if (newOvr) begin
        ovr     <= 1'b1;
        ovrSeen <= 1'b0;
      end else if (statRd && ovr) begin
        ovrSeen <= 1'b1;
      end else if (dataRd && ovrSeen) begin
        ovr     <= 1'b0;
        ovrSeen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_rx_pkg::*;
#(
  parameter int MAX_WL = 24,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              rie,
  input  logic [SLOT_W-1:0] slotCfg,
  input  logic [1:0]        wlCode,
  input  logic              fsWordLen,
  input  logic              sclk,
  input  logic              fsIn,
  input  logic              sdIn,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [MAX_WL-1:0] rdData,
  output logic              irq
);
  rxStrobeT strb;
  logic     rxFull, ovr;

  tdm_slot_rx_ctrl #(.MAX_WL(MAX_WL), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .slotCfg(slotCfg),
    .wlCode(wlCode), .fsWordLen(fsWordLen), .sclk(sclk), .fsIn(fsIn),
    .strb(strb)
  );

  tdm_slot_rx_dp #(.MAX_WL(MAX_WL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdIn(sdIn), .wlCode(wlCode),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rxFull(rxFull),
    .ovr(ovr)
  );

  assign irq = rxFull & rie;
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk (
  input logic clk,
  input logic rstN,
  input logic rie,
  input logic irq,
  input logic enable,
  input logic rdEn,
  input logic rdAddr,
  input logic shift,
  input logic xfer,
  input logic rxFull,
  input logic ovr
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN) !rie |-> !irq); // R7
  AST_IRQ_AFTER_XFER: assert property (@(posedge clk) disable iff (!rstN) (xfer && rie) |=> (irq || !rie)); // R7
  AST_FULL_ON_XFER: assert property (@(posedge clk) disable iff (!rstN) xfer |=> rxFull); // R6
  AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rstN) (rdEn && !rdAddr && !xfer) |=> !rxFull); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN) $rose(ovr) |-> ($past(rxFull) && $past(xfer))); // R8
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN) (ovr && !(rdEn && !rdAddr)) |=> ovr); // R9
  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rstN) !enable |-> !shift); // R10
endmodule

bind tdm_slot_rx tdm_slot_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .rie(rie), .irq(irq), .enable(enable),
  .rdEn(rdEn), .rdAddr(rdAddr), .shift(strb.shift), .xfer(strb.xfer),
  .rxFull(rxFull), .ovr(ovr)
);

// File: tb/sim_tdm_slot_rx.sv
`timescale 1ns/1ps
module sim_tdm_slot_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0, enable = 1'b0, rie = 1'b0, fsWordLen = 1'b1;
  logic [4:0]  slotCfg = 5'd3;
  logic [1:0]  wlCode = 2'b00;
  logic        sclk = 1'b0, fsIn = 1'b0, sdIn = 1'b0, rdEn = 1'b0, rdAddr = 1'b0;
  logic [23:0] rdData;
  logic        irq;
  int          nChecks = 0, nFails = 0;
  logic [23:0] expW [32];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tdm_slot_rx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .rie(rie), .slotCfg(slotCfg),
    .wlCode(wlCode), .fsWordLen(fsWordLen), .sclk(sclk), .fsIn(fsIn),
    .sdIn(sdIn), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic int wlOf(input logic [1:0] c);
    case (c) 2'b00: return 8; 2'b01: return 12; 2'b10: return 16; default: return 24; endcase
  endfunction

  function automatic logic [23:0] statOf(input bit frm, input bit ov, input bit full);
    return {21'd0, frm, ov, full};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input bit a, output logic [23:0] v);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0; rdAddr = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic bitOut(input logic d, input logic f);
    @(negedge clk); sdIn = d; fsIn = f; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic checkWord(input logic [23:0] w, input bit frm, input string req);
    logic [23:0] v;
    readReg(1'b1, v); check({req, " status"}, v, statOf(frm, 1'b0, 1'b1));
    check("R7 irq while full", {23'd0, irq}, {23'd0, rie});
    readReg(1'b0, v); check({req, " data"}, v, w);
    readReg(1'b1, v); check("R6 full cleared by data read", v, statOf(frm, 1'b0, 1'b0));
    check("R7 irq after read", {23'd0, irq}, 24'd0);
  endtask

  task automatic sendFrame(input int n, input int wl, input bit bitMode, input bit fsWord,
                           input bit tailFs, input bit doRead, input string req);
    for (int s = 0; s < n; s++) begin
      logic [23:0] w;
      w = 24'($urandom & ((32'd1 << wl) - 1));
      expW[s] = w;
      for (int b = wl - 1; b >= 0; b--) begin
        logic f;
        f = bitMode ? (tailFs && s == n - 1 && b == 0) : (fsWord && s == 0);
        bitOut(w[b], f);
      end
      if (doRead) checkWord(w, s == 0, req);
    end
  endtask

  task automatic runCfg(input logic [1:0] wc, input int slots, input bit bitMode,
                        input bit ieOn, input bit syncTwice, input string req);
    doReset();
    wlCode = wc; slotCfg = 5'(slots - 1); fsWordLen = ~bitMode; rie = ieOn;
    enable = 1'b1;
    bitOut(1'b0, bitMode);
    sendFrame(slots, wlOf(wc), bitMode, 1'b1, syncTwice, 1'b1, req);
    sendFrame(slots, wlOf(wc), bitMode, syncTwice, 1'b0, 1'b1,
              syncTwice ? req : "R3 wrap without sync");
    enable = 1'b0;
    bitOut(1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [23:0] v;
    void'($urandom(32'd2024));
    doReset();
    // R1 reset state
    readReg(1'b1, v); check("R1 status after reset", v, 24'd0);
    readReg(1'b0, v); check("R1 data after reset", v, 24'd0);
    check("R1 irq after reset", {23'd0, irq}, 24'd0);

    // directed: R2 each word length, R5 both sync styles, R3 slot counts
    runCfg(2'b00, 4, 1'b0, 1'b1, 1'b1, "R2 8-bit word sync");
    runCfg(2'b10, 3, 1'b1, 1'b1, 1'b0, "R5 bit sync 16-bit");
    runCfg(2'b01, 2, 1'b1, 1'b0, 1'b1, "R2 12-bit no irq");
    runCfg(2'b11, 32, 1'b0, 1'b1, 1'b0, "R4 24-bit 32 slots");

    // random mix
    for (int i = 0; i < 6; i++) begin
      runCfg(2'($urandom % 4), 2 + int'($urandom % 5), 1'($urandom % 2),
             1'($urandom % 2), 1'($urandom % 2), "R3 random frame");
    end

    // R8 / R9 overrun
    doReset();
    wlCode = 2'b00; slotCfg = 5'd1; fsWordLen = 1'b1; rie = 1'b1; enable = 1'b1;
    bitOut(1'b0, 1'b0);
    sendFrame(2, 8, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    enable = 1'b0;
    readReg(1'b0, v); check("R8 newest word overwrites", v, expW[1]);
    readReg(1'b1, v); check("R9 data read alone keeps overrun", v, statOf(1'b0, 1'b1, 1'b0));
    readReg(1'b1, v); check("R9 status read alone keeps overrun", v, statOf(1'b0, 1'b1, 1'b0));
    readReg(1'b0, v);
    readReg(1'b1, v); check("R9 status then data clears overrun", v, statOf(1'b0, 1'b0, 1'b0));

    // R10 disabled, then enabled mid-frame
    doReset();
    wlCode = 2'b00; slotCfg = 5'd1; fsWordLen = 1'b1; rie = 1'b1;
    bitOut(1'b0, 1'b0);
    sendFrame(2, 8, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    readReg(1'b1, v); check("R10 nothing captured while disabled", v, 24'd0);
    for (int b = 7; b >= 0; b--) bitOut(1'($urandom % 2), 1'b1);
    enable = 1'b1;
    for (int b = 7; b >= 0; b--) bitOut(1'($urandom % 2), 1'b0);
    readReg(1'b1, v); check("R10 waits for next frame sync", v, 24'd0);
    sendFrame(2, 8, 1'b0, 1'b1, 1'b0, 1'b1, "R10 capture after sync");
    enable = 1'b0;

    done = 1'b1;
    finishRun();
  end
endmodule